// File: doc/BRIEF.md
# Dual-Buffer Sequential Address Controller

This block produces the address sequence for a 4K-word memory that is read or written in order. The memory is divided into two buffers. Each buffer has a programmable first and last address and its own flow mode. A host programs the buffers through a small command port. It writes or reads a register picked by the three low address bits, and the value moves on the low twelve data bits. The same port reads the end-of-buffer flag status and clears the flags.

The sequential side has an advance enable. Each enabled clock moves the pointer one word forward. When the pointer is at the last address of the active buffer, that buffer's end flag drops low. The pointer then takes one of two actions. In chaining mode it jumps to the first address of the other buffer. In stop mode it holds at the last address. A load input places any 12-bit address in the pointer and makes active the buffer that holds that address. A buffer whose bounds are not valid is never entered.

The reset is asynchronous and active low. It returns the block to a known configuration at once.

Top module: `dual_buf_seq_addr`

## Requirements
- R1: While `rstN` is low, and at once when it falls, the outputs and registers take these values: `ptr`=0, `eobN`=2'b11, buffer 1 active, buffer 1 first=0 and last=4095, buffer 2 first=4095 and last=0 (invalid), both flow modes chaining.
- R2: A command access is `cmdSel`=1. With `cmdWr`=1 it is a write, which takes effect at the clock edge. With `cmdWr`=0 it is a read, and `cmdRdata` shows the result in the same cycle. The codes in `cmdAddr[2:0]` are: 000 buffer 1 first, 001 buffer 1 last, 010 buffer 2 first, 011 buffer 2 last. The value is in bits 11:0, and a read returns 0 in bits 15:12. `cmdRdata` is 0 when no read is in progress.
- R3: During a command access, `cmdAddr[11:3]` and `cmdWdata[15:12]` have no effect.
- R4: When `seqAdv`=1, `seqLoad`=0 and `ptr` is not the active buffer's last address, `ptr` becomes (`ptr`+1) mod 4096 on the next edge.
- R5: When `seqAdv`=1, `seqLoad`=0 and `ptr` equals the active buffer's last address, that buffer's flag goes low (`eobN[0]` for buffer 1, `eobN[1]` for buffer 2). In chaining mode, `ptr` moves to the other buffer's first address and that buffer becomes active.
- R6: Code 100 is the flow register. Bit 0 sets the mode of buffer 1 and bit 1 the mode of buffer 2, with 0 = chaining and 1 = stop. In stop mode, an advance at the last address lowers the flag and leaves `ptr` unchanged.
- R7: A buffer is valid only when first <= last. In chaining mode, if the other buffer is invalid, `ptr` returns to the first address of the active buffer, and the active buffer does not change.
- R8: A write to code 101 sets each flag whose bit is 1 in `cmdWdata[1:0]` back to high (bit 0 = flag 1, bit 1 = flag 2). If a flag is set and cleared in the same cycle, the set wins.
- R9: A read of code 101 returns `eobN` in bits 1:0 and 0 in the bits above.
- R10: Codes 110 and 111 are reserved. A write to them changes nothing, and a read from them returns 0.
- R11: `seqLoad`=1 loads `seqLoadAddr` into `ptr` on the next edge and takes priority over `seqAdv`. The new active buffer is buffer 1 if the address is inside its valid range, else buffer 2 if the address is inside its valid range, else the active buffer does not change.
- R12: When `seqAdv`=0 and `seqLoad`=0, `ptr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequential port and for command writes |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdSel | input | 1 | Command access select |
| cmdWr | input | 1 | 1 = command write, 0 = command read |
| cmdAddr | input | 12 | Command address; only bits 2:0 are decoded |
| cmdWdata | input | 16 | Command write data; only the low bits are used |
| cmdRdata | output | 16 | Command read data, available in the same cycle |
| seqAdv | input | 1 | Advance the pointer on this edge |
| seqLoad | input | 1 | Load the pointer on this edge |
| seqLoadAddr | input | 12 | Address to load |
| ptr | output | 12 | Current sequential address |
| eobN | output | 2 | End-of-buffer flags, active low; bit 0 = buffer 1 |

## Verification
Pointer moves, flag changes and command writes appear one clock edge after the inputs that cause them. Reads on `cmdRdata` are combinational and appear in the same cycle. Reset takes effect as soon as `rstN` falls. The bench drives its inputs a quarter period after the rising edge. It updates its behavioural model on the rising edge, and it compares `ptr`, `eobN` and `cmdRdata` with the model on the falling edge. Directed checks sample registered results once, after the one edge that produces them. They sample read data after the inputs have settled and before the next edge. They sample the asynchronous reset a moment after it is applied.

// File: rtl/dbsq_pkg.sv
package dbsq_pkg;
  parameter int ADDR_W = 12;
  parameter int DATA_W = 16;
  parameter int NBUF   = 2;

  localparam logic [2:0] CODE_FIRST1 = 3'b000;
  localparam logic [2:0] CODE_LAST1  = 3'b001;
  localparam logic [2:0] CODE_FIRST2 = 3'b010;
  localparam logic [2:0] CODE_LAST2  = 3'b011;
  localparam logic [2:0] CODE_FLOW   = 3'b100;
  localparam logic [2:0] CODE_FLAG   = 3'b101;

  // strobes from control to datapath
  typedef struct packed {
    logic            adv;
    logic            load;
    logic [NBUF-1:0] clr;
  } strobe_t;
endpackage

// File: rtl/dbsq_ctrl.sv
module dbsq_ctrl
  import dbsq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdSel,
  input  logic                     cmdWr,
  input  logic [AW-1:0]            cmdAddr,
  input  logic [DW-1:0]            cmdWdata,
  input  logic                     seqAdv,
  input  logic                     seqLoad,
  input  logic [NBUF-1:0]          flagN,
  output logic [DW-1:0]            cmdRdata,
  output strobe_t                  strb,
  output logic [NBUF-1:0][AW-1:0]  bufFirst,
  output logic [NBUF-1:0][AW-1:0]  bufLast,
  output logic [NBUF-1:0]          stopMode
);
  localparam int PADW = DW - AW;
  localparam int FPAD = DW - NBUF;

  logic [2:0] code;
  logic       wrEn;
  logic       rdEn;

  assign code = cmdAddr[2:0];
  assign wrEn = cmdSel && cmdWr;
  assign rdEn = cmdSel && !cmdWr;

  genvar b;
  generate
    for (b = 0; b < NBUF; b++) begin : g_buf
      localparam logic [2:0]    FCODE = 3'(2 * b);
      localparam logic [2:0]    LCODE = 3'(2 * b + 1);
      localparam logic [AW-1:0] FRST  = (b == 0) ? '0 : '1;
      localparam logic [AW-1:0] LRST  = (b == 0) ? '1 : '0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bufFirst[b] <= FRST;
          bufLast[b]  <= LRST;
        end else if (wrEn) begin
          if (code == FCODE) bufFirst[b] <= cmdWdata[AW-1:0];
          if (code == LCODE) bufLast[b]  <= cmdWdata[AW-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopMode <= '0;
    end else if (wrEn && code == CODE_FLOW) begin
      stopMode <= cmdWdata[NBUF-1:0];
    end
  end

  always_comb begin
    strb.adv  = seqAdv;
    strb.load = seqLoad;
    strb.clr  = (wrEn && code == CODE_FLAG) ? cmdWdata[NBUF-1:0] : '0;
  end

  always_comb begin
    cmdRdata = '0;
    if (rdEn) begin
      case (code)
        CODE_FIRST1: cmdRdata = {{PADW{1'b0}}, bufFirst[0]};
        CODE_LAST1:  cmdRdata = {{PADW{1'b0}}, bufLast[0]};
        CODE_FIRST2: cmdRdata = {{PADW{1'b0}}, bufFirst[1]};
        CODE_LAST2:  cmdRdata = {{PADW{1'b0}}, bufLast[1]};
        CODE_FLOW:   cmdRdata = {{FPAD{1'b0}}, stopMode};
        CODE_FLAG:   cmdRdata = {{FPAD{1'b0}}, flagN};
        default:     cmdRdata = '0;
      endcase
    end
  end

  // R10
  rsv_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSel && cmdWr && cmdAddr[2:1] == 2'b11)
      |=> ($stable(bufFirst) && $stable(bufLast) && $stable(stopMode)));

  // R2
  no_read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdSel |-> (cmdRdata == '0));
endmodule

// File: rtl/dbsq_path.sv
module dbsq_path
  import dbsq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [NBUF-1:0][AW-1:0]  bufFirst,
  input  logic [NBUF-1:0][AW-1:0]  bufLast,
  input  logic [NBUF-1:0]          stopMode,
  input  logic [AW-1:0]            loadAddr,
  output logic [AW-1:0]            ptr,
  output logic [NBUF-1:0]          flagN
);
  logic            act;
  logic            actNxt;
  logic            other;
  logic [AW-1:0]   ptrNxt;
  logic [NBUF-1:0] flagNxt;
  logic [NBUF-1:0] bufValid;
  logic [NBUF-1:0] inRange;
  logic            atEnd;
  logic            hitEnd;

  genvar b;
  generate
    for (b = 0; b < NBUF; b++) begin : g_rng
      assign bufValid[b] = bufFirst[b] <= bufLast[b];
      assign inRange[b]  = bufValid[b] && (loadAddr >= bufFirst[b])
                           && (loadAddr <= bufLast[b]);
    end
  endgenerate

  assign other  = ~act;
  assign atEnd  = (ptr == bufLast[act]);
  assign hitEnd = strb.adv && !strb.load && atEnd;

  always_comb begin
    ptrNxt  = ptr;
    actNxt  = act;
    flagNxt = flagN | strb.clr;
    if (strb.load) begin
      ptrNxt = loadAddr;
      if (inRange[0])      actNxt = 1'b0;
      else if (inRange[1]) actNxt = 1'b1;
    end else if (strb.adv) begin
      if (atEnd) begin
        flagNxt[act] = 1'b0;
        if (!stopMode[act]) begin
          if (bufValid[other]) begin
            ptrNxt = bufFirst[other];
            actNxt = other;
          end else begin
            ptrNxt = bufFirst[act];
          end
        end
      end else begin
        ptrNxt = ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr   <= '0;
      act   <= 1'b0;
      flagN <= '1;
    end else begin
      ptr   <= ptrNxt;
      act   <= actNxt;
      flagN <= flagNxt;
    end
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.adv && !strb.load) |=> $stable(ptr));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && !strb.load && !atEnd) |=> (ptr == AW'($past(ptr) + 1'b1)));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitEnd |=> !flagN[$past(act)]);

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitEnd && stopMode[act]) |=> $stable(ptr));

  // R11
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (ptr == $past(loadAddr)));

  generate
    for (b = 0; b < NBUF; b++) begin : g_clr_chk
      // R8
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strb.clr[b] && !(hitEnd && act == 1'(b))) |=> flagN[b]);
    end
  endgenerate
endmodule

// File: rtl/dual_buf_seq_addr.sv
module dual_buf_seq_addr
  import dbsq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdSel,
  input  logic          cmdWr,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdWdata,
  output logic [DW-1:0] cmdRdata,
  input  logic          seqAdv,
  input  logic          seqLoad,
  input  logic [AW-1:0] seqLoadAddr,
  output logic [AW-1:0] ptr,
  output logic [1:0]    eobN
);
  strobe_t                 strb;
  logic [NBUF-1:0][AW-1:0] bufFirst;
  logic [NBUF-1:0][AW-1:0] bufLast;
  logic [NBUF-1:0]         stopMode;
  logic [NBUF-1:0]         flagN;

  dbsq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdSel(cmdSel), .cmdWr(cmdWr),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .seqAdv(seqAdv),
    .seqLoad(seqLoad), .flagN(flagN), .cmdRdata(cmdRdata), .strb(strb),
    .bufFirst(bufFirst), .bufLast(bufLast), .stopMode(stopMode)
  );

  dbsq_path #(.AW(AW)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .bufFirst(bufFirst),
    .bufLast(bufLast), .stopMode(stopMode), .loadAddr(seqLoadAddr),
    .ptr(ptr), .flagN(flagN)
  );

  assign eobN = flagN;
endmodule

// File: tb/dual_buf_seq_addr_bench.sv
module dual_buf_seq_addr_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdSel = 1'b0;
  logic        cmdWr = 1'b0;
  logic [11:0] cmdAddr = '0;
  logic [15:0] cmdWdata = '0;
  logic [15:0] cmdRdata;
  logic        seqAdv = 1'b0;
  logic        seqLoad = 1'b0;
  logic [11:0] seqLoadAddr = '0;
  logic [11:0] ptr;
  logic [1:0]  eobN;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference
  int mFirst[2];
  int mLast[2];
  int mStop[2];
  int mFlag[2];
  int mPtr;
  int mAct;

  dual_buf_seq_addr u_dual_buf_seq_addr (
    .clk(clk), .rstN(rstN), .cmdSel(cmdSel), .cmdWr(cmdWr),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdRdata(cmdRdata),
    .seqAdv(seqAdv), .seqLoad(seqLoad), .seqLoadAddr(seqLoadAddr),
    .ptr(ptr), .eobN(eobN)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit mValid(int b);
    return mFirst[b] <= mLast[b];
  endfunction

  function automatic int mRead();
    if (!cmdSel || cmdWr) return 0;
    case (cmdAddr[2:0])
      3'd0: return mFirst[0];
      3'd1: return mLast[0];
      3'd2: return mFirst[1];
      3'd3: return mLast[1];
      3'd4: return mStop[0] + 2 * mStop[1];
      3'd5: return mFlag[0] + 2 * mFlag[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFirst[0] = 0;    mLast[0] = 4095;
      mFirst[1] = 4095; mLast[1] = 0;
      mStop[0] = 0; mStop[1] = 0;
      mFlag[0] = 1; mFlag[1] = 1;
      mPtr = 0; mAct = 0;
    end else begin
      int nf0, nf1, wd;
      wd = int'(cmdWdata);
      nf0 = mFlag[0]; nf1 = mFlag[1];
      if (cmdSel && cmdWr && cmdAddr[2:0] == 3'd5) begin
        if (wd % 2 == 1) nf0 = 1;
        if ((wd / 2) % 2 == 1) nf1 = 1;
      end
      if (seqLoad) begin
        int la;
        la = int'(seqLoadAddr);
        mPtr = la;
        if (mValid(0) && la >= mFirst[0] && la <= mLast[0]) mAct = 0;
        else if (mValid(1) && la >= mFirst[1] && la <= mLast[1]) mAct = 1;
      end else if (seqAdv) begin
        if (mPtr == mLast[mAct]) begin
          if (mAct == 0) nf0 = 0; else nf1 = 0;
          if (mStop[mAct] == 0) begin
            if (mValid(1 - mAct)) begin
              mAct = 1 - mAct;
              mPtr = mFirst[mAct];
            end else begin
              mPtr = mFirst[mAct];
            end
          end
        end else begin
          mPtr = (mPtr + 1) % 4096;
        end
      end
      mFlag[0] = nf0; mFlag[1] = nf1;
      if (cmdSel && cmdWr) begin
        case (cmdAddr[2:0])
          3'd0: mFirst[0] = wd % 4096;
          3'd1: mLast[0]  = wd % 4096;
          3'd2: mFirst[1] = wd % 4096;
          3'd3: mLast[1]  = wd % 4096;
          3'd4: begin mStop[0] = wd % 2; mStop[1] = (wd / 2) % 2; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4/R5/R6/R7/R11/R12 ptr model", int'(ptr), mPtr);
      chk("R5/R8 eobN model", int'(eobN), mFlag[0] + 2 * mFlag[1]);
      chk("R2/R9/R10 rdata model", int'(cmdRdata), mRead());
    end
  end

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic cmdWrite(logic [11:0] a, logic [15:0] d);
    cmdSel = 1'b1; cmdWr = 1'b1; cmdAddr = a; cmdWdata = d;
    tick();
    cmdSel = 1'b0; cmdWr = 1'b0;
  endtask

  task automatic readChk(string tag, logic [11:0] a, int exp);
    cmdSel = 1'b1; cmdWr = 1'b0; cmdAddr = a;
    #1;
    chk(tag, int'(cmdRdata), exp);
    tick();
    cmdSel = 1'b0;
  endtask

  task automatic load(logic [11:0] a);
    seqLoad = 1'b1; seqLoadAddr = a;
    tick();
    seqLoad = 1'b0;
  endtask

  task automatic adv(int n);
    for (int i = 0; i < n; i++) begin
      seqAdv = 1'b1;
      tick();
    end
    seqAdv = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 1);
    chk("R1 ptr in reset", int'(ptr), 0);
    chk("R1 eobN in reset", int'(eobN), 3);
    tick();
    rstN = 1'b1;
    tick();
    readChk("R1 first1 reset", 12'h000, 0);
    readChk("R1 last1 reset", 12'h001, 4095);
    readChk("R1 first2 reset", 12'h002, 4095);
    readChk("R1 last2 reset", 12'h003, 0);
    readChk("R1 flow reset", 12'h004, 0);

    // R3: upper address and data bits ignored
    cmdWrite(12'hFF8, 16'hF00A);
    cmdWrite(12'h0A9, 16'h500F);
    cmdWrite(12'h002, 16'h0064);
    cmdWrite(12'h003, 16'h0067);
    readChk("R3 first1 high bits", 12'h000, 10);
    readChk("R2 last1 readback", 12'h7F1, 15);
    readChk("R2 first2 readback", 12'h002, 100);
    readChk("R2 last2 readback", 12'h003, 103);

    // R11 load, R4 step, R5 chaining
    load(12'd10);
    chk("R11 load ptr", int'(ptr), 10);
    adv(5);
    chk("R4 step to end", int'(ptr), 15);
    adv(1);
    chk("R5 chain ptr", int'(ptr), 100);
    chk("R5 flag1 low", int'(eobN), 2);
    adv(4);
    chk("R5 chain back", int'(ptr), 10);
    chk("R5 both flags low", int'(eobN), 0);
    readChk("R9 status read", 12'h005, 0);

    // R8 clearing
    cmdWrite(12'h005, 16'h0001);
    chk("R8 clear flag1 only", int'(eobN), 1);
    cmdWrite(12'h005, 16'h0003);
    chk("R8 clear both", int'(eobN), 3);
    readChk("R9 status after clear", 12'h005, 3);

    // R6 stop mode on buffer 2
    cmdWrite(12'h004, 16'h0002);
    readChk("R6 flow readback", 12'h004, 2);
    load(12'd101);
    adv(2);
    chk("R4 step in buffer 2", int'(ptr), 103);
    adv(1);
    chk("R6 stop holds ptr", int'(ptr), 103);
    chk("R6 stop lowers flag2", int'(eobN), 1);
    adv(2);
    chk("R6 stays stopped", int'(ptr), 103);
    cmdWrite(12'h005, 16'h0003);

    // R10 reserved codes
    cmdWrite(12'h006, 16'h0FFF);
    cmdWrite(12'h007, 16'h0003);
    readChk("R10 reserved write no effect", 12'h000, 10);
    readChk("R10 reserved write flow kept", 12'h004, 2);
    readChk("R10 reserved read 110", 12'h006, 0);
    readChk("R10 reserved read 111", 12'h007, 0);

    // R8 set wins over clear in same cycle
    cmdWrite(12'h004, 16'h0000);
    load(12'd14);
    adv(1);
    seqAdv = 1'b1; cmdSel = 1'b1; cmdWr = 1'b1; cmdAddr = 12'h005;
    cmdWdata = 16'h0001;
    tick();
    seqAdv = 1'b0; cmdSel = 1'b0; cmdWr = 1'b0;
    chk("R8 set wins flag1", int'(eobN), 2);
    chk("R5 chain with clear", int'(ptr), 100);
    cmdWrite(12'h005, 16'h0003);

    // R7 invalid other buffer
    cmdWrite(12'h002, 16'd200);
    cmdWrite(12'h003, 16'd100);
    load(12'd12);
    adv(3);
    adv(1);
    chk("R7 wrap to own start", int'(ptr), 10);
    chk("R7 flag1 low", int'(eobN), 2);
    load(12'd150);
    chk("R11 load outside buffers", int'(ptr), 150);
    adv(1);
    chk("R4 step outside", int'(ptr), 151);

    // R12 idle
    tick(); tick(); tick();
    chk("R12 idle hold", int'(ptr), 151);

    // R4 wrap at top
    cmdWrite(12'h001, 16'd20);
    load(12'd4095);
    adv(1);
    chk("R4 wrap to zero", int'(ptr), 0);

    // R11 load priority over advance
    seqLoad = 1'b1; seqAdv = 1'b1; seqLoadAddr = 12'd5;
    tick();
    seqLoad = 1'b0; seqAdv = 1'b0;
    chk("R11 load beats advance", int'(ptr), 5);

    // R1 asynchronous reset mid-run
    rstN = 1'b0;
    #1;
    chk("R1 async ptr", int'(ptr), 0);
    chk("R1 async eobN", int'(eobN), 3);
    tick();
    rstN = 1'b1;
    tick();
    readChk("R1 first2 after async", 12'h002, 4095);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule